// File: doc/BRIEF.md
# Serial EEPROM Boot Reader

This block fetches 16-bit words from a three-wire serial configuration EEPROM. It drives chip select, a serial clock and a data line toward the EEPROM, and it samples the EEPROM's data-out line. Every transaction has the same shape. Chip select rises. A read opcode follows, then a 6-bit word address. Sixteen data bits are then clocked back in, after which chip select drops.

When reset is released, an internal sequencer reads the whole 64-word image into a local image RAM, lowest address first. It then inspects the image. A first word of all ones or all zeros means no EEPROM is fitted. Otherwise a 48-bit station address is assembled from image bytes 20 to 25. After that the block raises `load_done`.

From then on a host can request any single word over a start/offset handshake. The block reads that word from the EEPROM and returns it with a one-cycle valid strobe.

Top module: `eeprom_boot_reader`

## Requirements
- R1: Each transaction raises `ee_cs` first. The first three bits shifted out on `ee_di` are 1, 1, 0 in that order.
- R2: The next six bits on `ee_di` are the word address, most-significant bit first.
- R3: For each bit, `ee_di` is set while `ee_sk` is low and held through the high and following low phases. Each `ee_sk` high phase lasts exactly CLK_PER_PHASE clocks.
- R4: After the address, 16 bits are captured from `ee_do` at the end of each `ee_sk` high phase, most-significant bit first, and form the returned word.
- R5: A transaction consists of exactly 25 `ee_sk` pulses. `ee_cs` drops after the 25th pulse, and `ee_sk` is never high while `ee_cs` is low.
- R6: After reset, words 0 to 63 are read in ascending address order, one transaction each, before `load_done` rises. `load_done` then stays high until the next reset.
- R7: If image word 0 equals 0xFFFF or 0x0000, `eeprom_absent` is 1 and `station_addr` is zero once `load_done` is high.
- R8: With an EEPROM present, `station_addr[47:40]` holds byte 20, which is the low byte of word 10. The remaining fields follow down to `station_addr[7:0]`, which holds byte 25, the high byte of word 12.
- R9: `busy` is 1 in the cycle after an accepted `start` and remains 1 until `word_valid` pulses for one cycle. In that cycle `busy` is already 0.
- R10: A `start` that arrives while `busy` is 1 is ignored. This includes the boot load. Such a `start` produces no extra transaction and no extra `word_valid`.
- R11: During and right after reset, `ee_cs` and `ee_sk` are 0, `busy` is 1 and `load_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, starts the boot load |
| start | input | 1 | Host request for one word read |
| offset | input | 6 | Word address of the host request |
| busy | output | 1 | Boot load or host read in progress |
| word_out | output | 16 | Last word returned to the host |
| word_valid | output | 1 | One-cycle strobe: `word_out` is new |
| load_done | output | 1 | Boot image loaded and decoded |
| eeprom_absent | output | 1 | Word 0 was blank, so no EEPROM is assumed |
| station_addr | output | 48 | Station address taken from the image |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the block with CLK_PER_PHASE set to 2 and all other parameters at their defaults. A full 64-word boot then takes about ten thousand clocks, so three complete boots fit in one run: a normal image, word 0 all ones, and word 0 all zeros. At two clocks per phase, the behavioural EEPROM model can also measure every high phase and notice a phase that is one clock short or long. The default image size and station address word offset keep the real address layout and the ascending boot order within reach.

// File: rtl/eeprom_boot_pkg.sv
package eeprom_boot_pkg;
  localparam logic [2:0] READ_OPCODE = 3'b110;

  typedef enum logic [1:0] {E_IDLE, E_SELECT, E_SHIFT} eng_e;
  typedef enum logic [1:0] {PH_SETUP, PH_HIGH, PH_HOLD} phase_e;
  typedef enum logic [2:0] {
    SQ_LOAD_REQ, SQ_LOAD_WAIT, SQ_EXTRACT, SQ_READY, SQ_HOST_WAIT
  } seq_e;
endpackage

// File: rtl/eeprom_bit_engine.sv
module eeprom_bit_engine
  import eeprom_boot_pkg::*;
#(
  parameter int DIV = 625,
  parameter int AW  = 6,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] addr,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          cs,
  output logic          sk,
  output logic          di,
  input  logic          dout_in
);
  localparam int TXB  = 3 + AW;
  localparam int TOTB = TXB + DW;
  localparam int CW   = (DIV < 2) ? 1 : $clog2(DIV);
  localparam int BW   = $clog2(TOTB + 1);

  eng_e            st;
  phase_e          ph;
  logic [CW-1:0]   div_cnt;
  logic [BW-1:0]   bit_idx;
  logic [TXB-1:0]  tx_sr;
  logic [DW-1:0]   rx_sr;
  logic            phase_end;

  assign phase_end = (div_cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= E_IDLE;
      ph      <= PH_SETUP;
      div_cnt <= '0;
      bit_idx <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      cs      <= 1'b0;
      sk      <= 1'b0;
      di      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: begin
          if (go) begin
            cs      <= 1'b1;
            sk      <= 1'b0;
            di      <= 1'b0;
            tx_sr   <= {READ_OPCODE, addr};
            div_cnt <= '0;
            st      <= E_SELECT;
          end
        end
        E_SELECT: begin
          if (phase_end) begin
            div_cnt <= '0;
            st      <= E_SHIFT;
            ph      <= PH_SETUP;
            bit_idx <= '0;
            di      <= tx_sr[TXB-1];
            tx_sr   <= tx_sr << 1;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        E_SHIFT: begin
          if (!phase_end) begin
            div_cnt <= div_cnt + 1'b1;
          end else begin
            div_cnt <= '0;
            case (ph)
              PH_SETUP: begin
                sk <= 1'b1;
                ph <= PH_HIGH;
              end
              PH_HIGH: begin
                sk <= 1'b0;
                if (bit_idx >= BW'(TXB))
                  rx_sr <= {rx_sr[DW-2:0], dout_in};
                ph <= PH_HOLD;
              end
              default: begin
                if (bit_idx == BW'(TOTB - 1)) begin
                  cs    <= 1'b0;
                  di    <= 1'b0;
                  done  <= 1'b1;
                  rdata <= rx_sr;
                  st    <= E_IDLE;
                end else begin
                  bit_idx <= bit_idx + 1'b1;
                  di      <= tx_sr[TXB-1];
                  tx_sr   <= tx_sr << 1;
                end
                ph <= PH_SETUP;
              end
            endcase
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // R3: data line frozen while the clock is high and on its falling cycle
  p_di_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (sk || $past(sk)) |-> $stable(di));

  // R5: no clock pulse without chip select
  p_sk_needs_cs_r5: assert property (@(posedge clk) disable iff (rst)
    sk |-> cs);

  // R5: completion strobe coincides with deselect
  p_done_deselects_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !cs);
endmodule

// File: rtl/eeprom_image_ram.sv
module eeprom_image_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_boot_reader.sv
module eeprom_boot_reader
  import eeprom_boot_pkg::*;
#(
  parameter int CLK_PER_PHASE = 625,
  parameter int WORD_ADDR_W   = 6,
  parameter int WORD_W        = 16,
  parameter int IMAGE_WORDS   = 64,
  parameter int ADDR_BYTE_OFS = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [WORD_ADDR_W-1:0] offset,
  output logic                   busy,
  output logic [WORD_W-1:0]      word_out,
  output logic                   word_valid,
  output logic                   load_done,
  output logic                   eeprom_absent,
  output logic [47:0]            station_addr,
  output logic                   ee_cs,
  output logic                   ee_sk,
  output logic                   ee_di,
  input  logic                   ee_do
);
  localparam int AW       = WORD_ADDR_W;
  localparam int MAC_WORD = ADDR_BYTE_OFS / 2;

  seq_e            sq;
  logic [AW-1:0]   idx;
  logic [2:0]      ex_cnt;
  logic [WORD_W-1:0] w0, m0, m1;
  logic            eng_go, eng_done;
  logic [AW-1:0]   eng_addr;
  logic [WORD_W-1:0] eng_rdata;
  logic            ram_we;
  logic [AW-1:0]   ram_raddr;
  logic [WORD_W-1:0] ram_rdata;
  logic            blank_w0;

  eeprom_bit_engine #(.DIV(CLK_PER_PHASE), .AW(AW), .DW(WORD_W)) u_engine (
    .clk(clk), .rst(rst), .go(eng_go), .addr(eng_addr), .done(eng_done),
    .rdata(eng_rdata), .cs(ee_cs), .sk(ee_sk), .di(ee_di), .dout_in(ee_do)
  );

  eeprom_image_ram #(.DEPTH(IMAGE_WORDS), .AW(AW), .DW(WORD_W)) u_image (
    .clk(clk), .we(ram_we), .waddr(idx), .wdata(eng_rdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  assign ram_we   = (sq == SQ_LOAD_WAIT) && eng_done;
  assign blank_w0 = (w0 == '0) || (w0 == '1);

  always_comb begin
    eng_go   = 1'b0;
    eng_addr = idx;
    if (sq == SQ_LOAD_REQ) begin
      eng_go = 1'b1;
    end else if (sq == SQ_READY && start) begin
      eng_go   = 1'b1;
      eng_addr = offset;
    end
    case (ex_cnt)
      3'd0:    ram_raddr = '0;
      3'd1:    ram_raddr = AW'(MAC_WORD);
      3'd2:    ram_raddr = AW'(MAC_WORD + 1);
      default: ram_raddr = AW'(MAC_WORD + 2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq            <= SQ_LOAD_REQ;
      idx           <= '0;
      ex_cnt        <= '0;
      w0            <= '0;
      m0            <= '0;
      m1            <= '0;
      busy          <= 1'b1;
      load_done     <= 1'b0;
      eeprom_absent <= 1'b0;
      station_addr  <= '0;
      word_out      <= '0;
      word_valid    <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      case (sq)
        SQ_LOAD_REQ: sq <= SQ_LOAD_WAIT;
        SQ_LOAD_WAIT: begin
          if (eng_done) begin
            if (idx == AW'(IMAGE_WORDS - 1)) begin
              sq     <= SQ_EXTRACT;
              ex_cnt <= '0;
            end else begin
              idx <= idx + 1'b1;
              sq  <= SQ_LOAD_REQ;
            end
          end
        end
        SQ_EXTRACT: begin
          ex_cnt <= ex_cnt + 1'b1;
          case (ex_cnt)
            3'd1: w0 <= ram_rdata;
            3'd2: m0 <= ram_rdata;
            3'd3: m1 <= ram_rdata;
            3'd4: begin
              eeprom_absent <= blank_w0;
              station_addr  <= blank_w0 ? '0 :
                {m0[7:0], m0[15:8], m1[7:0], m1[15:8],
                 ram_rdata[7:0], ram_rdata[15:8]};
              load_done <= 1'b1;
              busy      <= 1'b0;
              sq        <= SQ_READY;
            end
            default: ;
          endcase
        end
        SQ_READY: begin
          if (start) begin
            busy <= 1'b1;
            sq   <= SQ_HOST_WAIT;
          end
        end
        SQ_HOST_WAIT: begin
          if (eng_done) begin
            word_out   <= eng_rdata;
            word_valid <= 1'b1;
            busy       <= 1'b0;
            sq         <= SQ_READY;
          end
        end
        default: sq <= SQ_READY;
      endcase
    end
  end

  // R9: strobe only once busy has dropped
  p_valid_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> !busy);

  // R6: load completion is sticky
  p_loaded_sticks_r6: assert property (@(posedge clk) disable iff (rst)
    load_done |=> load_done);

  // R7: absent image yields an empty station address
  p_absent_blank_r7: assert property (@(posedge clk) disable iff (rst)
    (load_done && eeprom_absent) |-> (station_addr == '0));

  // R10: with no accepted request the EEPROM stays deselected
  p_cs_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (load_done && !busy) |-> !ee_cs);
endmodule

// File: tb/test_eeprom_boot_reader.sv
`timescale 1ns/1ps
module test_eeprom_boot_reader;
  localparam int DIV = 2;
  localparam int NV  = 8;
  localparam logic [5:0]  OFFS [NV] = '{6'd0, 6'd1, 6'd10, 6'd12, 6'd21, 6'd32, 6'd42, 6'd63};
  localparam logic [15:0] EXPW [NV] = '{16'h807F, 16'h817E, 16'h2211, 16'h6655,
                                        16'h956A, 16'hA05F, 16'hAA55, 16'hBF40};

  logic clk = 0, rst = 1, start = 0;
  logic [5:0] offset = '0;
  logic busy, word_valid, load_done, eeprom_absent, ee_cs, ee_sk, ee_di;
  logic ee_do = 0;
  logic [15:0] word_out;
  logic [47:0] station_addr;

  always #4 clk = ~clk;

  eeprom_boot_reader #(.CLK_PER_PHASE(DIV)) i_eeprom_boot_reader (
    .clk(clk), .rst(rst), .start(start), .offset(offset), .busy(busy),
    .word_out(word_out), .word_valid(word_valid), .load_done(load_done),
    .eeprom_absent(eeprom_absent), .station_addr(station_addr),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int w0mode = 0;

  function automatic logic [15:0] memval(input logic [5:0] a, input int m);
    if (a == 0 && m == 1) return 16'hFFFF;
    if (a == 0 && m == 2) return 16'h0000;
    if (a == 10) return 16'h2211;
    if (a == 11) return 16'h4433;
    if (a == 12) return 16'h6655;
    return {2'b10, a, 2'b01, ~a};
  endfunction

  // behavioural EEPROM and protocol monitor
  int m_nbits = 0, m_hi = 0, trans_cnt = 0, boot_next = 0;
  int bad_op = 0, bad_len = 0, bad_tim = 0, bad_di = 0, bad_order = 0;
  logic [2:0] m_op = '0;
  logic [5:0] m_addr = '0, last_addr = '0;
  logic m_cs_q = 0, m_sk_q = 0, m_di_rise = 0;
  logic [15:0] m_word;

  always @(negedge clk) begin
    if (rst) begin
      m_cs_q = 0; m_sk_q = 0; m_nbits = 0; boot_next = 0; trans_cnt = 0; ee_do = 0;
    end else begin
      if (ee_cs && !m_cs_q) begin m_nbits = 0; m_op = '0; m_addr = '0; end
      if (ee_sk && !m_sk_q) begin
        m_nbits++; m_di_rise = ee_di; m_hi = 1;
        if (m_nbits <= 3) m_op = {m_op[1:0], ee_di};
        else if (m_nbits <= 9) m_addr = {m_addr[4:0], ee_di};
        else begin
          m_word = memval(m_addr, w0mode);
          ee_do = m_word[25 - m_nbits];
        end
      end else if (ee_sk && m_sk_q) m_hi++;
      if (!ee_sk && m_sk_q) begin
        if (m_hi != DIV) bad_tim++;
        if (ee_di != m_di_rise) bad_di++;
      end
      if (!ee_cs && m_cs_q) begin
        if (m_nbits != 25) bad_len++;
        if (m_op != 3'b110) bad_op++;
        trans_cnt++; last_addr = m_addr; ee_do = 0;
        if (!load_done) begin
          if (m_addr != boot_next[5:0]) bad_order++;
          boot_next++;
        end
      end
      m_cs_q = ee_cs; m_sk_q = ee_sk;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_boot(input int mode);
    int k;
    w0mode = mode;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    for (k = 0; k < 20000 && !load_done; k++) @(negedge clk);
    chk(load_done, "R6 load_done", load_done, 1);
  endtask

  task automatic host_read(input logic [5:0] o, output logic [15:0] w);
    @(negedge clk); start = 1; offset = o;
    @(negedge clk); start = 0;
    chk(busy == 1, "R9 busy after start", busy, 1);
    for (int k = 0; k < 2000 && !word_valid; k++) @(negedge clk);
    chk(word_valid == 1, "R9 word_valid seen", word_valid, 1);
    chk(busy == 0, "R9 busy low with valid", busy, 0);
    w = word_out;
    @(negedge clk);
    chk(word_valid == 0, "R9 valid is one cycle", word_valid, 0);
  endtask

  initial begin
    logic [15:0] w;
    int tc;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(ee_cs == 0, "R11 cs", ee_cs, 0);
    chk(ee_sk == 0, "R11 sk", ee_sk, 0);
    chk(busy == 1, "R11 busy", busy, 1);
    chk(load_done == 0, "R11 load_done", load_done, 0);
    rst = 0;
    // R10: request during boot is ignored
    @(negedge clk); start = 1; offset = 6'd5;
    @(negedge clk); start = 0;
    for (int k = 0; k < 20000 && !load_done; k++) @(negedge clk);
    chk(load_done, "R6 load_done", load_done, 1);
    chk(trans_cnt == 64, "R10 R6 boot transactions", trans_cnt, 64);
    chk(boot_next == 64, "R6 words loaded", boot_next, 64);
    chk(bad_order == 0, "R6 R2 ascending addresses", bad_order, 0);
    chk(bad_op == 0, "R1 opcode 110", bad_op, 0);
    chk(bad_tim == 0, "R3 high phase length", bad_tim, 0);
    chk(bad_di == 0, "R3 di stable over pulse", bad_di, 0);
    chk(bad_len == 0, "R5 25 pulses then deselect", bad_len, 0);
    chk(eeprom_absent == 0, "R7 present", eeprom_absent, 0);
    chk(station_addr == 48'h112233445566, "R8 station address", station_addr, 48'h112233445566);
    // vector table of host reads
    for (int i = 0; i < NV; i++) begin
      host_read(OFFS[i], w);
      chk(w == EXPW[i], "R4 word value", w, EXPW[i]);
      chk(last_addr == OFFS[i], "R2 address sent", last_addr, OFFS[i]);
    end
    // R10: second start while busy
    tc = trans_cnt;
    @(negedge clk); start = 1; offset = 6'd1;
    @(negedge clk); start = 1; offset = 6'd42;
    @(negedge clk); start = 0;
    for (int k = 0; k < 2000 && !word_valid; k++) @(negedge clk);
    chk(word_out == 16'h817E, "R10 first request served", word_out, 16'h817E);
    chk(last_addr == 6'd1, "R10 address of first request", last_addr, 1);
    repeat (400) @(negedge clk);
    chk(trans_cnt == tc + 1, "R10 no extra transaction", trans_cnt, tc + 1);
    chk(bad_tim == 0 && bad_di == 0 && bad_len == 0 && bad_op == 0, "R3 R5 host reads", bad_tim + bad_di + bad_len + bad_op, 0);
    // R7: blank word 0 variants
    do_boot(1);
    chk(eeprom_absent == 1, "R7 absent on FFFF", eeprom_absent, 1);
    chk(station_addr == 0, "R7 address zero on FFFF", station_addr, 0);
    do_boot(2);
    chk(eeprom_absent == 1, "R7 absent on 0000", eeprom_absent, 1);
    chk(station_addr == 0, "R7 address zero on 0000", station_addr, 0);
    host_read(6'd0, w);
    chk(w == 16'h0000, "R4 blank word read", w, 0);
    do_boot(0);
    chk(eeprom_absent == 0, "R7 present after reboot", eeprom_absent, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule